// File: doc/BRIEF.md
# Shift-Add Tap Multiplier Element

This element forms the product of one data sample and one filter coefficient without a binary multiplier. The coefficient is a 12-bit descriptor that holds five small shift fields. Each field drives its own unit, and each unit produces one copy of the sample. A unit can pass the sample unchanged, shift it left, or return zero. The element adds the five copies and returns a wide product word. All of this logic is combinational.

A surrounding filter engine uses the element once per tap. The engine fetches a descriptor, presents it together with a stored sample, and adds the product into its own accumulator. The engine also handles the tap sequence, the memories and any sign choice.

The descriptor holds the following fields:
- A 1-bit gate field.
- A 2-bit field for the "pair" shifter.
- Three 3-bit fields for the "triple" shifters.

The product is wide enough that no combination of sample and descriptor can overflow it.

Top module: `shadd_tap`

## Requirements
- R1: The gate field is `desc_i[0]`. When it is 0, the gate unit adds the sample unshifted. When it is 1, the gate unit adds zero.
- R2: The pair field is `desc_i[2:1]`. A nonzero value n makes the pair unit add the sample shifted left by n places, which is the sample times 2^n.
- R3: The three triple fields are `desc_i[5:3]`, `desc_i[8:6]` and `desc_i[11:9]`. Each nonzero value n adds the sample shifted left by n places, which is the sample times 2^n.
- R4: A pair or triple field that holds 0 adds nothing to the product.
- R5: `prod_o` is exactly the sum of the five unit terms. It is SMP_W+9 bits wide, so the largest coefficient of 393 (descriptor 0xFFE) gives an exact result for both extreme sample values.
- R6: With SIGNED_IN=1 (the default), the sample is taken as two's complement and sign-extended before shifting, so negative samples give correctly signed products.
- R7: A sample of 220 with descriptor 0x006 (gate 0, pair field 3) gives a product of 1980.
- R8: The product has no register on its path. A change at the inputs appears at `prod_o` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| smp_i | input | SMP_W (16) | Data sample, two's complement when SIGNED_IN=1 |
| desc_i | input | 12 | Shift descriptor: gate, pair and three triple fields |
| prod_o | output | SMP_W+9 (25) | Sum of the five shifted terms |

## Verification
Several units can contribute in the same evaluation, and the cases that matter most are the ones where their terms overlap. The first such case is the pass-through from the gate unit landing together with a shifted term. The second is all three triple units at their maximum shift together with the pair unit at its maximum, which drives the sum to its extreme. The bench applies these mixed descriptors with both the largest positive sample and the most negative sample, and compares the result with the product worked out by hand from the field values. A descriptor with every field set to 1 gives equal shifted terms from three units, so a dropped or duplicated term changes the total.

// File: rtl/shadd_pkg.sv
package shadd_pkg;
  localparam int GATE_W  = 1;
  localparam int PAIR_W  = 2;
  localparam int TRIP_W  = 3;
  localparam int N_TRIP  = 3;
  localparam int DESC_W  = GATE_W + PAIR_W + N_TRIP * TRIP_W;
  localparam int N_TERMS = 2 + N_TRIP;
  // largest coefficient: 1 + 2^3 + 3*2^7 = 393 < 2^9
  localparam int GROW_W  = 9;

  typedef struct packed {
    logic [TRIP_W-1:0] trip2;
    logic [TRIP_W-1:0] trip1;
    logic [TRIP_W-1:0] trip0;
    logic [PAIR_W-1:0] pair;
    logic              gate;
  } desc_t;
endpackage

// File: rtl/shadd_gate_unit.sv
module shadd_gate_unit #(
  parameter int W = 25
) (
  input  logic signed [W-1:0] ext_i,
  input  logic                kill_i,
  output logic signed [W-1:0] term_o
);
  always_comb begin
    if (kill_i) term_o = '0;
    else        term_o = ext_i;
  end
endmodule

// File: rtl/shadd_shift_unit.sv
module shadd_shift_unit #(
  parameter int W   = 25,
  parameter int FLD = 3
) (
  input  logic signed [W-1:0]   ext_i,
  input  logic        [FLD-1:0] amt_i,
  output logic signed [W-1:0]   term_o
);
  always_comb begin
    if (amt_i == '0) term_o = '0;
    else             term_o = ext_i <<< amt_i;
  end
endmodule

// File: rtl/shadd_sum.sv
module shadd_sum #(
  parameter int W = 25,
  parameter int N = 5
) (
  input  logic signed [W-1:0] term_i [N],
  output logic signed [W-1:0] sum_o
);
  logic signed [W-1:0] acc;
  always_comb begin
    acc = '0;
    for (int k = 0; k < N; k++) acc = acc + term_i[k];
  end
  assign sum_o = acc;
endmodule

// File: rtl/shadd_tap.sv
module shadd_tap
  import shadd_pkg::*;
#(
  parameter int SMP_W     = 16,
  parameter bit SIGNED_IN = 1'b1,
  localparam int PROD_W   = SMP_W + GROW_W
) (
  input  logic [SMP_W-1:0]  smp_i,
  input  logic [DESC_W-1:0] desc_i,
  output logic [PROD_W-1:0] prod_o
);
  desc_t               dsc;
  logic signed [PROD_W-1:0] ext;
  logic signed [PROD_W-1:0] terms [N_TERMS];
  logic signed [PROD_W-1:0] total;
  logic [TRIP_W-1:0]   trip_amt [N_TRIP];

  assign dsc = desc_t'(desc_i);
  assign trip_amt[0] = dsc.trip0;
  assign trip_amt[1] = dsc.trip1;
  assign trip_amt[2] = dsc.trip2;

  generate
    if (SIGNED_IN) begin : g_sext
      assign ext = {{GROW_W{smp_i[SMP_W-1]}}, smp_i};
    end else begin : g_zext
      assign ext = {{GROW_W{1'b0}}, smp_i};
    end
  endgenerate

  shadd_gate_unit #(.W(PROD_W)) u_gate (
    .ext_i (ext),
    .kill_i(dsc.gate),
    .term_o(terms[0])
  );

  shadd_shift_unit #(.W(PROD_W), .FLD(PAIR_W)) u_pair (
    .ext_i (ext),
    .amt_i (dsc.pair),
    .term_o(terms[1])
  );

  generate
    for (genvar t = 0; t < N_TRIP; t++) begin : g_trip
      shadd_shift_unit #(.W(PROD_W), .FLD(TRIP_W)) u_trip (
        .ext_i (ext),
        .amt_i (trip_amt[t]),
        .term_o(terms[2+t])
      );
    end
  endgenerate

  shadd_sum #(.W(PROD_W), .N(N_TERMS)) u_sum (
    .term_i(terms),
    .sum_o (total)
  );

  assign prod_o = total;
endmodule

// File: rtl/shadd_tap_chk.sv
module shadd_tap_chk
  import shadd_pkg::*;
#(
  parameter int SMP_W     = 16,
  parameter bit SIGNED_IN = 1'b1,
  localparam int PROD_W   = SMP_W + GROW_W
) (
  input logic [SMP_W-1:0]  smp_i,
  input logic [DESC_W-1:0] desc_i,
  input logic [PROD_W-1:0] prod_o
);
  longint s_v, p_v, s_abs, p_abs;

  always_comb begin
    s_v = SIGNED_IN ? longint'($signed(smp_i)) : longint'(smp_i);
    p_v = longint'($signed(prod_o));
    s_abs = (s_v < 0) ? -s_v : s_v;
    p_abs = (p_v < 0) ? -p_v : p_v;

    // R1
    pass_thru_chk: assert (desc_i != '0 || p_v == s_v)
      else $error("pass-through term wrong");
    // R1
    gate_block_chk: assert (desc_i != DESC_W'(1) || p_v == 0)
      else $error("gated descriptor not zero");
    // R2
    pair_only_chk: assert (!(desc_i[0] && desc_i[DESC_W-1:3] == '0 && desc_i[2:1] != '0)
                           || p_v == s_v * (longint'(1) << desc_i[2:1]))
      else $error("pair unit term wrong");
    // R5
    no_overflow_chk: assert (p_abs <= 393 * s_abs)
      else $error("product exceeds coefficient bound");
    // R6
    sign_chk: assert (!(s_v < 0 && desc_i != DESC_W'(1)) || p_v < 0)
      else $error("negative sample lost its sign");
  end
endmodule

bind shadd_tap shadd_tap_chk #(.SMP_W(SMP_W), .SIGNED_IN(SIGNED_IN)) u_chk (
  .smp_i (smp_i),
  .desc_i(desc_i),
  .prod_o(prod_o)
);

// File: tb/shadd_tap_bench.sv
module shadd_tap_bench;
  localparam int SW = 16;
  localparam int PW = SW + 9;
  localparam int NV = 14;

  localparam logic signed [SW-1:0] V_SMP [NV] = '{
    16'sd220, 16'sd100, 16'sd100, 16'sd5, 16'sd7, 16'sd3, 16'sd9,
    -16'sd3, -16'sd220, 16'sd32767, -16'sd32768, 16'sd1, 16'sd10, 16'sd0};
  localparam logic [11:0] V_DSC [NV] = '{
    12'h006, 12'h000, 12'h001, 12'h003, 12'h039, 12'h081, 12'hA01,
    12'h000, 12'h006, 12'hFFE, 12'hFFE, 12'hFFE, 12'h248, 12'hFFE};
  localparam logic signed [PW-1:0] V_EXP [NV] = '{
    25'sd1980, 25'sd100, 25'sd0, 25'sd10, 25'sd896, 25'sd12, 25'sd288,
    -25'sd3, -25'sd1980, 25'sd12877431, -25'sd12877824, 25'sd393, 25'sd70, 25'sd0};
  localparam string V_TAG [NV] = '{
    "R7", "R1", "R1", "R2", "R3", "R3", "R3",
    "R6", "R6", "R5", "R5", "R5", "R4", "R5"};

  logic clk;
  logic [SW-1:0] smp;
  logic [11:0]   dsc;
  logic [PW-1:0] prod;
  int n_chk, n_bad;
  bit done;

  shadd_tap u_shadd_tap (.smp_i(smp), .desc_i(dsc), .prod_o(prod));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic signed [PW-1:0] exp, input string tag);
    n_chk++;
    if ($signed(prod) !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (smp=%0d desc=%h)",
               tag, $signed(prod), exp, $signed(smp), dsc);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    smp = '0; dsc = '0;
    @(negedge clk);
    check('0, "R4 idle");
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      smp = V_SMP[i]; dsc = V_DSC[i];
      @(negedge clk);
      check(V_EXP[i], V_TAG[i]);
    end
    // R8: output follows input within the same half-cycle
    @(posedge clk);
    smp = 16'sd50; dsc = 12'h006;
    #1 check(25'sd450, "R8 first");
    smp = 16'sd51;
    #1 check(25'sd459, "R8 second");
    // R4: each zero field alone leaves only the gate term
    @(posedge clk);
    smp = 16'sd123; dsc = 12'h000;
    @(negedge clk); check(25'sd123, "R4 all zero");
    // R2 all pair shifts
    for (int n = 1; n < 4; n++) begin
      @(posedge clk);
      smp = -16'sd17; dsc = 12'(n << 1) | 12'h001;
      @(negedge clk); check(-25'sd17 * (25'sd1 <<< n), "R2 sweep");
    end
    // R3 each triple field at 7 independently
    for (int f = 0; f < 3; f++) begin
      @(posedge clk);
      smp = 16'sd3; dsc = 12'(7 << (3 + 3*f)) | 12'h001;
      @(negedge clk); check(25'sd384, "R3 field sweep");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule